// File: doc/BRIEF.md
# Triggered DAC Data Controller

This block is the digital front end of a 12-bit digital-to-analog converter. A simple word-addressed register bus reaches four registers: control, data, status and a software-trigger strobe. Each time a start condition occurs while the converter is idle, the block extracts a 12-bit code from the data register, presents it on `dac_code` with a one-cycle `dac_load` pulse, and then holds the converter busy for a programmable settle time. A settle counter stands in for the analog conversion. When the count ends, BUSY clears and FINISH is set.

A start comes from one of two places. With triggering disabled, the start is a write to the data register. With triggering enabled, the start is the selected source: a software strobe, the synchronised external pin in one of four detect modes, one of four timer pulses, or one of two PWM pulses. A triggered conversion can raise a DMA request that asks for the next data word. If another trigger arrives before that word is written, the block flags an under-run and converts the old code again. FINISH and under-run each drive an interrupt through their own enable bit.

Word map (`bus_addr`): 0 = control, 1 = data, 2 = status, 3 = software trigger. Control fields: [0] trigger enable, [1] left align, [2] DMA enable, [3] finish interrupt enable, [4] under-run interrupt enable, [7:5] source select, [9:8] pin detect mode, [23:16] settle count. All other bits read 0.

The conversion machine has two named states:
- `CV_IDLE`: waits for a start. The transition *start accepted* goes to `CV_SETTLE` and loads the counter with the settle count.
- `CV_SETTLE`: counts down. The transition *count at zero* returns to `CV_IDLE` and raises the done pulse. Every other cycle stays in `CV_SETTLE`.

Top module: `dac_trig_ctrl`

## Requirements
- R1: With control bit 0 = 0, a bus write to word 1 starts a conversion of the newly written value. A data write while busy only updates the data register and starts nothing.
- R2: With control bit 0 = 1, data writes start nothing. Only the source chosen by control[7:5] starts a conversion: 0 software strobe, 1 external pin, 2..5 timer pulse 0..3, 6 PWM pulse 0, 7 PWM pulse 1. Pulses on sources that are not selected have no effect.
- R3: Writing 1 to bit 0 of word 3 is a one-cycle software strobe. Writing 0 does nothing, and word 3 always reads 0.
- R4: The external pin passes through two synchroniser flops. Control[9:8] selects the detect mode: 0 low level, 1 high level, 2 falling edge, 3 rising edge. An edge mode converts once per edge. A level mode converts again each time the converter is idle while the level holds.
- R5: With control bit 1 = 1, the code is data bits [15:4]. With it at 0, the code is data bits [11:0]. All other data bits are ignored.
- R6: A conversion holds BUSY for settle count + 1 cycles, beginning in the cycle of `dac_load`, and sets FINISH as BUSY falls. Starts that arrive while BUSY is set are ignored.
- R7: The status word holds FINISH at bit 0, under-run at bit 1 and BUSY at bit 8. Writing 1 to bit 0 or bit 1 clears that flag. BUSY is not writable.
- R8: With control bit 2 = 1, every triggered conversion raises `dma_req`. A write to the data register lowers it.
- R9: A triggered conversion that starts while `dma_req` is still high, with no data write in that cycle, sets the under-run flag and converts the unchanged code again.
- R10: `irq_done` is FINISH AND control bit 3. `irq_udr` is under-run AND control bit 4.
- R11: After reset the control, data and status words read 0, `dma_req`, `dac_busy`, `dac_load` and both interrupts are 0, and `dac_code` is 0.
- R12: `dac_code` changes only in a cycle where `dac_load` is high. `dac_load` is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| ext_pin | input | 1 | External trigger pin, asynchronous |
| tmr_pulse | input | 4 | Timer trigger pulses |
| pwm_pulse | input | 2 | PWM trigger pulses |
| dac_code | output | 12 | Code held for the converter |
| dac_load | output | 1 | One-cycle strobe when a new code is latched |
| dac_busy | output | 1 | Conversion in progress |
| dma_req | output | 1 | Request for the next data word |
| irq_done | output | 1 | Conversion-finished interrupt |
| irq_udr | output | 1 | DMA under-run interrupt |

## Verification
Conversions are started in every way the block allows: data writes in both alignments (with noise in the ignored bits), software strobes, selected and unselected timer and PWM pulses, and the external pin in all four detect modes. A scoreboard matches each `dac_load` against the queued expected code. This shows that a wrong source, a lost start or an extra start is a real fault and not a timing artefact. Back-to-back starts during BUSY separate the rule that ignores them from the rule that queues them. The edge and level pin modes are told apart by counting loads while the pin is held. The DMA sequence (write between triggers, then no write) separates a normal request from an under-run with a repeated code.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int SETTLE_W = 8;
    localparam int SEL_W    = 3;

    typedef enum logic [0:0] {
        CV_IDLE   = 1'b0,
        CV_SETTLE = 1'b1
    } conv_state_t;

    typedef enum logic [1:0] {
        PIN_LOW  = 2'd0,
        PIN_HIGH = 2'd1,
        PIN_FALL = 2'd2,
        PIN_RISE = 2'd3
    } pin_mode_t;

    typedef struct packed {
        logic [SETTLE_W-1:0] settle;
        pin_mode_t           pin_mode;
        logic [SEL_W-1:0]    sel;
        logic                udr_ie;
        logic                done_ie;
        logic                dma_en;
        logic                left;
        logic                trig_en;
    } ctrl_t;

endpackage

// File: rtl/dacfe_trig_sel.sv
module dacfe_trig_sel
    import dacfe_pkg::*;
#(
    parameter int N_TMR       = 4,
    parameter int N_PWM       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_strobe,
    input  logic             ext_pin,
    input  logic [N_TMR-1:0] tmr_pulse,
    input  logic [N_PWM-1:0] pwm_pulse,
    input  logic [SEL_W-1:0] sel,
    input  pin_mode_t        pin_mode,
    output logic             trig_evt
);

    localparam int N_SRC = 2 + N_TMR + N_PWM;

    // sh[SYNC_STAGES-1] is the synchronised pin, sh[SYNC_STAGES] its previous value
    logic [SYNC_STAGES:0] sh;
    logic                 pin_now, pin_prev, pin_evt;
    logic [N_SRC-1:0]     src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[SYNC_STAGES-1:0], ext_pin};
    end

    assign pin_now  = sh[SYNC_STAGES-1];
    assign pin_prev = sh[SYNC_STAGES];

    always_comb begin
        unique case (pin_mode)
            PIN_LOW:  pin_evt = !pin_now;
            PIN_HIGH: pin_evt = pin_now;
            PIN_FALL: pin_evt = !pin_now && pin_prev;
            PIN_RISE: pin_evt = pin_now && !pin_prev;
            default:  pin_evt = 1'b0;
        endcase
    end

    assign src[0] = sw_strobe;
    assign src[1] = pin_evt;
    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        assign src[2+i] = tmr_pulse[i];
    end
    for (genvar j = 0; j < N_PWM; j++) begin : g_pwm
        assign src[2+N_TMR+j] = pwm_pulse[j];
    end

    always_comb begin
        trig_evt = 1'b0;
        for (int k = 0; k < N_SRC; k++) begin
            if (int'(sel) == k) trig_evt = src[k];
        end
    end

endmodule

// File: rtl/dacfe_conv_fsm.sv
module dacfe_conv_fsm
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle,
    input  logic [CODE_W-1:0]   code_in,
    output logic                busy,
    output logic                load,
    output logic                done,
    output logic [CODE_W-1:0]   code
);

    conv_state_t         state, nxt;
    logic [SETTLE_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            CV_IDLE:   if (start)     nxt = CV_SETTLE;
            CV_SETTLE: if (cnt == '0) nxt = CV_IDLE;
            default:                  nxt = CV_IDLE;
        endcase
    end

    // state register and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CV_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == CV_IDLE && start) cnt <= settle;
            else if (state == CV_SETTLE && cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            load <= 1'b0;
        end else begin
            load <= (state == CV_IDLE) && start;
            if ((state == CV_IDLE) && start) code <= code_in;
        end
    end

    assign busy = (state == CV_SETTLE);
    assign done = (state == CV_SETTLE) && (cnt == '0);

endmodule

// File: rtl/dac_trig_ctrl.sv
module dac_trig_ctrl
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int N_TMR  = 4,
    parameter int N_PWM  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ext_pin,
    input  logic [N_TMR-1:0]  tmr_pulse,
    input  logic [N_PWM-1:0]  pwm_pulse,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_load,
    output logic              dac_busy,
    output logic              dma_req,
    output logic              irq_done,
    output logic              irq_udr
);

    localparam int LEFT_LSB = 16 - CODE_W;

    ctrl_t              ctrl;
    logic [31:0]        data_q;
    logic               fin_q, udr_q, dma_q;
    logic               wr_ctrl, wr_data, wr_stat, sw_strobe;
    logic               trig_evt, start_req, accept, hw_accept, conv_done;
    logic [CODE_W-1:0]  code_src;

    assign wr_ctrl   = bus_we && (bus_addr == 2'd0);
    assign wr_data   = bus_we && (bus_addr == 2'd1);
    assign wr_stat   = bus_we && (bus_addr == 2'd2);
    assign sw_strobe = bus_we && (bus_addr == 2'd3) && bus_wdata[0];

    dacfe_trig_sel #(.N_TMR(N_TMR), .N_PWM(N_PWM), .SYNC_STAGES(2)) u_sel (
        .clk(clk), .rst_n(rst_n), .sw_strobe(sw_strobe), .ext_pin(ext_pin),
        .tmr_pulse(tmr_pulse), .pwm_pulse(pwm_pulse), .sel(ctrl.sel),
        .pin_mode(ctrl.pin_mode), .trig_evt(trig_evt)
    );

    assign start_req = ctrl.trig_en ? trig_evt : wr_data;
    assign accept    = start_req && !dac_busy;
    assign hw_accept = accept && ctrl.trig_en && ctrl.dma_en;

    always_comb begin
        if (wr_data) code_src = ctrl.left ? bus_wdata[LEFT_LSB +: CODE_W] : bus_wdata[CODE_W-1:0];
        else         code_src = ctrl.left ? data_q[LEFT_LSB +: CODE_W]    : data_q[CODE_W-1:0];
    end

    dacfe_conv_fsm #(.CODE_W(CODE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(accept), .settle(ctrl.settle),
        .code_in(code_src), .busy(dac_busy), .load(dac_load),
        .done(conv_done), .code(dac_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl   <= '0;
            data_q <= '0;
            fin_q  <= 1'b0;
            udr_q  <= 1'b0;
            dma_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl.trig_en  <= bus_wdata[0];
                ctrl.left     <= bus_wdata[1];
                ctrl.dma_en   <= bus_wdata[2];
                ctrl.done_ie  <= bus_wdata[3];
                ctrl.udr_ie   <= bus_wdata[4];
                ctrl.sel      <= bus_wdata[7:5];
                ctrl.pin_mode <= pin_mode_t'(bus_wdata[9:8]);
                ctrl.settle   <= bus_wdata[23:16];
            end
            if (wr_data) data_q <= bus_wdata;

            if (conv_done)                    fin_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) fin_q <= 1'b0;

            if (hw_accept && dma_q && !wr_data) udr_q <= 1'b1;
            else if (wr_stat && bus_wdata[1])   udr_q <= 1'b0;

            if (hw_accept)                     dma_q <= 1'b1;
            else if (wr_data || !ctrl.dma_en)  dma_q <= 1'b0;
        end
    end

    assign dma_req  = dma_q;
    assign irq_done = fin_q && ctrl.done_ie;
    assign irq_udr  = udr_q && ctrl.udr_ie;

    always_comb begin
        unique case (bus_addr)
            2'd0:    bus_rdata = {8'd0, ctrl.settle, 6'd0, ctrl.pin_mode, ctrl.sel,
                                  ctrl.udr_ie, ctrl.done_ie, ctrl.dma_en, ctrl.left, ctrl.trig_en};
            2'd1:    bus_rdata = data_q;
            2'd2:    bus_rdata = {23'd0, dac_busy, 6'd0, udr_q, fin_q};
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dac_load,
    input logic              dac_busy,
    input logic [CODE_W-1:0] dac_code,
    input logic              dma_req,
    input logic              fin_q,
    input logic              udr_q
);

    assert_load_starts_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dac_load |-> dac_busy && !$past(dac_busy));

    assert_code_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_load |-> $stable(dac_code));

    assert_busy_blocks_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dac_busy |=> !dac_load);

    assert_finish_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_busy) |-> fin_q);

    assert_dma_from_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> dac_load);

    assert_udr_from_conv_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr_q) |-> dac_load && dma_req);

endmodule

bind dac_trig_ctrl dacfe_checker #(.CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .dac_load(dac_load), .dac_busy(dac_busy),
    .dac_code(dac_code), .dma_req(dma_req), .fin_q(fin_q), .udr_q(udr_q)
);

// File: tb/dac_trig_ctrl_test.sv
module dac_trig_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ext_pin = 1'b0;
    logic [3:0]  tmr_pulse = '0;
    logic [1:0]  pwm_pulse = '0;
    logic [11:0] dac_code;
    logic        dac_load, dac_busy, dma_req, irq_done, irq_udr;

    int          n_cmp = 0, n_bad = 0, load_cnt = 0;
    logic [11:0] exp_q[$];
    bit          free_run = 1'b0;
    logic [11:0] free_code = '0;

    always #2 clk = ~clk;

    dac_trig_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
        .tmr_pulse(tmr_pulse), .pwm_pulse(pwm_pulse), .dac_code(dac_code),
        .dac_load(dac_load), .dac_busy(dac_busy), .dma_req(dma_req),
        .irq_done(irq_done), .irq_udr(irq_udr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && dac_load) begin
            load_cnt++;
            if (free_run) chk(dac_code == free_code, "R4", "level-mode code", dac_code, free_code);
            else if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected load", dac_code, 0);
            else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                chk(dac_code == e, "R5", "converted code", dac_code, e);
            end
        end
    end

    function automatic logic [31:0] mk(bit ten, bit left, bit dma, bit die, bit uie,
                                       int sel, int pm);
        return {8'd0, 8'd3, 6'd0, 2'(pm), 3'(sel), uie, die, dma, left, ten};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle;
        do @(negedge clk); while (dac_busy);
        @(negedge clk);
    endtask

    task automatic pulse_tmr(input int i);
        @(negedge clk); tmr_pulse[i] = 1'b1;
        @(negedge clk); tmr_pulse = '0;
    endtask

    task automatic pulse_pwm(input int i);
        @(negedge clk); pwm_pulse[i] = 1'b1;
        @(negedge clk); pwm_pulse = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R12", "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int base, bcnt;
        cyc(3); rst_n = 1'b1; cyc(2);

        // R11 reset state
        rd(2'd0, d); chk(d == 0, "R11", "ctrl after reset", d, 0);
        rd(2'd1, d); chk(d == 0, "R11", "data after reset", d, 0);
        rd(2'd2, d); chk(d == 0, "R11", "status after reset", d, 0);
        chk({dma_req, dac_busy, dac_load, irq_done, irq_udr} == 0, "R11", "outputs after reset",
            {dma_req, dac_busy, dac_load, irq_done, irq_udr}, 0);
        chk(dac_code == 0, "R11", "code after reset", dac_code, 0);

        // R1 write start, right alignment, R6 busy length, R7 status
        wr(2'd0, mk(0, 0, 0, 0, 0, 0, 0));
        exp_q.push_back(12'h123);
        wr(2'd1, 32'hABCD_E123);
        rd(2'd2, d); chk(d[8] == 1'b1, "R7", "busy bit while converting", d, 32'h100);
        bcnt = 0;
        while (dac_busy) begin bcnt++; @(negedge clk); end
        chk(bcnt == 4, "R6", "busy cycles", bcnt, 4);
        rd(2'd2, d); chk(d == 32'h1, "R6", "finish after conversion", d, 1);
        chk(irq_done == 1'b0, "R10", "irq_done masked", irq_done, 0);
        wr(2'd2, 32'h101);
        rd(2'd2, d); chk(d == 0, "R7", "finish w1c", d, 0);

        // R5 left alignment with junk in ignored bits
        wr(2'd0, mk(0, 1, 0, 0, 0, 0, 0));
        exp_q.push_back(12'h5A6);
        wr(2'd1, 32'hFFFF_5A6F);
        wait_idle();

        // R1 write while busy ignored
        wr(2'd0, mk(0, 0, 0, 0, 0, 0, 0));
        exp_q.push_back(12'h111);
        wr(2'd1, 32'h111);
        wr(2'd1, 32'h222);
        wait_idle(); cyc(3);
        rd(2'd1, d); chk(d == 32'h222, "R1", "data reg after busy write", d, 32'h222);
        chk(dac_code == 12'h111, "R1", "code after busy write", dac_code, 12'h111);

        // R2 / R3 software strobe
        wr(2'd0, mk(1, 0, 0, 0, 0, 0, 0));
        base = load_cnt;
        wr(2'd1, 32'h345); cyc(6);
        chk(load_cnt == base, "R2", "data write in trigger mode", load_cnt - base, 0);
        wr(2'd3, 32'h0); cyc(6);
        chk(load_cnt == base, "R3", "strobe write of zero", load_cnt - base, 0);
        exp_q.push_back(12'h345);
        wr(2'd3, 32'h1);
        wait_idle();
        rd(2'd3, d); chk(d == 0, "R3", "strobe reads zero", d, 0);

        // R2 timer 1 selected, R6 retrigger while busy
        wr(2'd0, mk(1, 0, 0, 0, 0, 3, 0));
        base = load_cnt;
        pulse_tmr(0); pulse_pwm(0); cyc(4);
        chk(load_cnt == base, "R2", "unselected sources", load_cnt - base, 0);
        exp_q.push_back(12'h345);
        pulse_tmr(1); pulse_tmr(1);
        wait_idle();
        chk(load_cnt == base + 1, "R6", "trigger during busy", load_cnt - base, 1);

        // R2 PWM 1 selected
        wr(2'd0, mk(1, 0, 0, 0, 0, 7, 0));
        wr(2'd1, 32'h456);
        base = load_cnt;
        wr(2'd3, 32'h1); cyc(4);
        chk(load_cnt == base, "R2", "strobe when PWM1 selected", load_cnt - base, 0);
        exp_q.push_back(12'h456);
        pulse_pwm(1);
        wait_idle();

        // R4 pin edge modes
        wr(2'd0, mk(1, 0, 0, 0, 0, 1, 3));
        base = load_cnt;
        exp_q.push_back(12'h456);
        ext_pin = 1'b1; cyc(20);
        chk(load_cnt == base + 1, "R4", "rising edge once", load_cnt - base, 1);
        wr(2'd0, mk(1, 0, 0, 0, 0, 1, 2));
        base = load_cnt;
        exp_q.push_back(12'h456);
        ext_pin = 1'b0; cyc(20);
        chk(load_cnt == base + 1, "R4", "falling edge once", load_cnt - base, 1);

        // R4 pin level modes
        free_run = 1'b1; free_code = 12'h456;
        wr(2'd0, mk(1, 0, 0, 0, 0, 1, 1));
        base = load_cnt; cyc(10);
        chk(load_cnt == base, "R4", "high level while pin low", load_cnt - base, 0);
        ext_pin = 1'b1; cyc(20); ext_pin = 1'b0; cyc(12);
        chk(load_cnt - base >= 3, "R4", "high level repeats", load_cnt - base, 3);
        ext_pin = 1'b1; cyc(5);
        wr(2'd0, mk(1, 0, 0, 0, 0, 1, 0));
        base = load_cnt; cyc(10);
        chk(load_cnt == base, "R4", "low level while pin high", load_cnt - base, 0);
        ext_pin = 1'b0; cyc(20); ext_pin = 1'b1; cyc(15);
        chk(load_cnt - base >= 3, "R4", "low level repeats", load_cnt - base, 3);
        free_run = 1'b0;

        // R8 / R9 / R10 DMA and interrupts on timer 0
        wr(2'd0, mk(1, 0, 1, 1, 1, 2, 0));
        wr(2'd2, 32'h3);
        exp_q.push_back(12'h456);
        pulse_tmr(0);
        chk(dma_req == 1'b1, "R8", "dma request raised", dma_req, 1);
        wait_idle();
        chk(irq_done == 1'b1, "R10", "irq_done enabled", irq_done, 1);
        wr(2'd2, 32'h1);
        chk(irq_done == 1'b0, "R10", "irq_done after clear", irq_done, 0);
        wr(2'd1, 32'h789);
        chk(dma_req == 1'b0, "R8", "dma request cleared by write", dma_req, 0);
        exp_q.push_back(12'h789);
        pulse_tmr(0);
        wait_idle();
        rd(2'd2, d); chk(d[1] == 1'b0, "R9", "no under-run after refill", d, 1);
        exp_q.push_back(12'h789);
        pulse_tmr(0);
        wait_idle();
        rd(2'd2, d); chk(d[1] == 1'b1, "R9", "under-run flagged", d, 3);
        chk(irq_udr == 1'b1, "R10", "irq_udr enabled", irq_udr, 1);
        wr(2'd2, 32'h2);
        rd(2'd2, d); chk(d[1] == 1'b0, "R7", "under-run w1c", d, 1);
        chk(irq_udr == 1'b0, "R10", "irq_udr after clear", irq_udr, 0);

        cyc(5);
        chk(exp_q.size() == 0, "R12", "all expected loads seen", exp_q.size(), 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule